// File: doc/BRIEF.md
# DRAM Page Idle Close Timer

This block watches the DRAM banks of one row and decides when an open page has sat unused long enough that it should be closed. Every accepted access marks its bank's page as open and restarts that bank's idle count. Each clock in which an open bank sees no access advances its count. When the count reaches the programmed timeout, the bank raises a close (precharge) request toward the memory controller. The controller answers with an acknowledge, and only then does the page count as closed.

The timeout comes from a 4-bit code with a non-linear mapping. Codes with the top bit set turn idle closing off entirely. A mode bit selects whether two or four banks are tracked. When more than one bank is waiting to be closed, the lowest-numbered bank is offered first and the rest wait their turn. Row-address comparison and the actual precharge command sequence are handled elsewhere.

Top module: `pgidle_top`

## Requirements
- R1: For idle codes 0 to 7 the timeout N is 0, 2, 4, 8, 10, 12, 16, 32 clocks. If a bank's last access is sampled at clock edge k, its close request is first visible in the cycle after edge k+N. With code 0 this is the cycle right after the access.
- R2: Any idle code with bit 3 set (values 8 to 15) never raises a close request, however long a page stays idle.
- R3: An access to an open bank restarts that bank's idle count. If the bank's request was already pending, the access withdraws it.
- R4: An access with `accValid` high to an enabled bank sets bit `accBank` of `pageOpen` from the next cycle on.
- R5: `closeBank` names the lowest-numbered bank whose timeout has expired. Other expired banks keep waiting and are offered one per acknowledge, in ascending order.
- R6: A `pageOpen` bit clears only in the cycle after `closeAck` is high while `closeReq` is high for that bank. A `closeAck` while `closeReq` is low changes nothing.
- R7: When `fourBank` is 0, only banks 0 and 1 are tracked. Accesses to banks 2 and 3 are ignored, `pageOpen[3:2]` stays 0, and `closeBank` is never 2 or 3.
- R8: After reset every page is closed and `closeReq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| idleCode | input | 4 | Idle timeout code; bit 3 set means never close |
| fourBank | input | 1 | 1 selects four tracked banks, 0 selects two |
| accValid | input | 1 | Access strobe |
| accBank | input | 2 | Bank index of the access |
| closeAck | input | 1 | Controller accepts the current close request |
| pageOpen | output | 4 | Open flag for each bank, bit i for bank i |
| closeReq | output | 1 | A close request is pending |
| closeBank | output | 2 | Bank index of the pending close request |

## Verification
An access or an acknowledge takes effect on `pageOpen` one edge after it is sampled. A close request appears N edges after the access edge. With code 0 that is the cycle that follows the access, since the request is decoded from registered state without a further register. The bench drives and samples on the falling edge. After an access it checks that `closeReq` is still low one cycle before the due cycle and high in the due cycle itself, so an off-by-one timeout is caught. For acknowledges and ignored accesses, the bench samples `pageOpen` one falling edge after the stimulus.

// File: rtl/pgidle_pkg.sv
package pgidle_pkg;
  localparam int NUM_BANKS = 4;
  localparam int BANK_W    = $clog2(NUM_BANKS);
  localparam int CNT_W     = 6;

  typedef struct packed {
    logic [NUM_BANKS-1:0] openSet;
    logic [NUM_BANKS-1:0] openClr;
    logic [NUM_BANKS-1:0] cntClr;
  } bankStrobe_t;

  function automatic logic [CNT_W-1:0] idleLimit(input logic [2:0] code);
    logic [CNT_W-1:0] lim;
    case (code)
      3'd0: lim = CNT_W'(0);
      3'd1: lim = CNT_W'(2);
      3'd2: lim = CNT_W'(4);
      3'd3: lim = CNT_W'(8);
      3'd4: lim = CNT_W'(10);
      3'd5: lim = CNT_W'(12);
      3'd6: lim = CNT_W'(16);
      default: lim = CNT_W'(32);
    endcase
    return lim;
  endfunction
endpackage

// File: rtl/pgidle_datapath.sv
module pgidle_datapath
  import pgidle_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  bankStrobe_t          strobe,
  input  logic [3:0]           idleCode,
  input  logic [NUM_BANKS-1:0] bankEn,
  output logic [NUM_BANKS-1:0] pageOpen,
  output logic [NUM_BANKS-1:0] expired
);
  logic [CNT_W-1:0] limit;
  logic             infinite;

  assign limit    = idleLimit(idleCode[2:0]);
  assign infinite = idleCode[3];

  for (genvar i = 0; i < NUM_BANKS; i++) begin : gBank
    logic [CNT_W-1:0] idleCnt;
    logic             openQ;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        openQ   <= 1'b0;
        idleCnt <= '0;
      end else begin
        if (strobe.openClr[i])      openQ <= 1'b0;
        else if (strobe.openSet[i]) openQ <= 1'b1;

        if (strobe.cntClr[i])                idleCnt <= '0;
        else if (openQ && idleCnt < limit)   idleCnt <= idleCnt + 1'b1;
      end
    end

    assign pageOpen[i] = openQ;
    assign expired[i]  = openQ && !infinite && bankEn[i] && (idleCnt >= limit);

    // R1: the idle count saturates and never passes the longest timeout
    assert_cnt_bound_R1: assert property (@(posedge clk) disable iff (!rstN)
      idleCnt <= CNT_W'(32));

    // R3: an access strobe restarts the count
    assert_cnt_restart_R3: assert property (@(posedge clk) disable iff (!rstN)
      strobe.cntClr[i] |=> idleCnt == '0);
  end
endmodule

// File: rtl/pgidle_ctrl.sv
module pgidle_ctrl
  import pgidle_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 accValid,
  input  logic [BANK_W-1:0]    accBank,
  input  logic                 closeAck,
  input  logic                 fourBank,
  input  logic [3:0]           idleCode,
  input  logic [NUM_BANKS-1:0] expired,
  input  logic [NUM_BANKS-1:0] pageOpen,
  output bankStrobe_t          strobe,
  output logic [NUM_BANKS-1:0] bankEn,
  output logic                 closeReq,
  output logic [BANK_W-1:0]    closeBank
);
  localparam int HALF = NUM_BANKS / 2;

  logic [NUM_BANKS-1:0] accHit;
  logic [NUM_BANKS-1:0] grant;

  for (genvar i = 0; i < NUM_BANKS; i++) begin : gEn
    if (i < HALF) begin : gLow
      assign bankEn[i] = 1'b1;
    end else begin : gHigh
      assign bankEn[i] = fourBank;
    end
  end

  always_comb begin
    closeReq  = 1'b0;
    closeBank = '0;
    for (int i = NUM_BANKS - 1; i >= 0; i--) begin
      if (expired[i]) begin
        closeReq  = 1'b1;
        closeBank = BANK_W'(i);
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_BANKS; i++) begin
      accHit[i] = accValid && (accBank == BANK_W'(i)) && bankEn[i];
      grant[i]  = closeReq && closeAck && (closeBank == BANK_W'(i));
    end
  end

  assign strobe.openSet = accHit;
  assign strobe.openClr = (grant & ~accHit) | ~bankEn;
  assign strobe.cntClr  = accHit | strobe.openClr;

  // R5: the offered bank is actually open
  assert_req_open_R5: assert property (@(posedge clk) disable iff (!rstN)
    closeReq |-> pageOpen[closeBank]);

  // R2: infinite mode never requests a close
  assert_infinite_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    idleCode[3] |-> !closeReq);

  // R4: an enabled access opens its page on the next cycle
  assert_access_opens_R4: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && bankEn[accBank]) |=> pageOpen[$past(accBank)]);

  // R6: an acknowledged close clears the page unless the same bank is accessed
  assert_ack_clears_R6: assert property (@(posedge clk) disable iff (!rstN)
    (closeReq && closeAck && !(accValid && accBank == closeBank))
      |=> !pageOpen[$past(closeBank)]);

  // R7: two-bank mode never offers an upper bank
  assert_two_bank_R7: assert property (@(posedge clk) disable iff (!rstN)
    (closeReq && !fourBank) |-> closeBank < BANK_W'(HALF));
endmodule

// File: rtl/pgidle_top.sv
module pgidle_top
  import pgidle_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [3:0]           idleCode,
  input  logic                 fourBank,
  input  logic                 accValid,
  input  logic [BANK_W-1:0]    accBank,
  input  logic                 closeAck,
  output logic [NUM_BANKS-1:0] pageOpen,
  output logic                 closeReq,
  output logic [BANK_W-1:0]    closeBank
);
  bankStrobe_t          strobe;
  logic [NUM_BANKS-1:0] bankEn;
  logic [NUM_BANKS-1:0] expired;

  pgidle_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accBank(accBank),
    .closeAck(closeAck), .fourBank(fourBank), .idleCode(idleCode),
    .expired(expired), .pageOpen(pageOpen), .strobe(strobe),
    .bankEn(bankEn), .closeReq(closeReq), .closeBank(closeBank)
  );

  pgidle_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .idleCode(idleCode),
    .bankEn(bankEn), .pageOpen(pageOpen), .expired(expired)
  );

  // R8: no request while every page is closed
  assert_idle_reset_R8: assert property (@(posedge clk) disable iff (!rstN)
    (pageOpen == '0) |-> !closeReq);
endmodule

// File: tb/sim_pgidle_top.sv
module sim_pgidle_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] idleCode = 4'd0;
  logic       fourBank = 1'b1;
  logic       accValid = 1'b0;
  logic [1:0] accBank = 2'd0;
  logic       closeAck = 1'b0;
  logic [3:0] pageOpen;
  logic       closeReq;
  logic [1:0] closeBank;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  pgidle_top u0 (
    .clk(clk), .rstN(rstN), .idleCode(idleCode), .fourBank(fourBank),
    .accValid(accValid), .accBank(accBank), .closeAck(closeAck),
    .pageOpen(pageOpen), .closeReq(closeReq), .closeBank(closeBank)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic access(input logic [1:0] b);
    accValid = 1'b1; accBank = b;
    @(negedge clk);
    accValid = 1'b0;
  endtask

  task automatic ack_once();
    closeAck = 1'b1;
    @(negedge clk);
    closeAck = 1'b0;
  endtask

  function automatic int limitOf(input int code);
    case (code)
      0: return 0; 1: return 2; 2: return 4; 3: return 8;
      4: return 10; 5: return 12; 6: return 16; default: return 32;
    endcase
  endfunction

  task automatic test_reset();
    check(pageOpen == 4'b0000, "R8 pageOpen after reset", pageOpen, 0);
    check(closeReq == 1'b0, "R8 closeReq after reset", closeReq, 0);
  endtask

  task automatic test_timeout(input int code, input logic [1:0] b);
    int n;
    n = limitOf(code);
    idleCode = 4'(code);
    access(b);
    check(pageOpen[b] == 1'b1, "R4 page opened", pageOpen[b], 1);
    if (n > 0) begin
      repeat (n - 1) @(negedge clk);
      check(closeReq == 1'b0, "R1 no request before timeout", closeReq, 0);
      @(negedge clk);
    end
    check(closeReq == 1'b1, "R1 request at timeout", closeReq, 1);
    check(closeBank == b, "R1 request bank", closeBank, b);
    ack_once();
    check(pageOpen[b] == 1'b0, "R6 ack closes page", pageOpen[b], 0);
  endtask

  task automatic test_restart();
    idleCode = 4'd3;
    access(2'd1);
    repeat (5) @(negedge clk);
    access(2'd1);
    repeat (7) @(negedge clk);
    check(closeReq == 1'b0, "R3 restarted count not expired", closeReq, 0);
    @(negedge clk);
    check(closeReq == 1'b1, "R3 restarted count expires", closeReq, 1);
    access(2'd1);
    check(closeReq == 1'b0, "R3 access withdraws request", closeReq, 0);
    repeat (8) @(negedge clk);
    ack_once();
    check(pageOpen == 4'b0000, "R6 all closed after restart test", pageOpen, 0);
  endtask

  task automatic test_infinite_and_order();
    idleCode = 4'b1010;
    access(2'd3);
    access(2'd1);
    access(2'd2);
    repeat (40) @(negedge clk);
    check(closeReq == 1'b0, "R2 infinite never closes", closeReq, 0);
    check(pageOpen == 4'b1110, "R2 pages stay open", pageOpen, 4'b1110);
    ack_once();
    check(pageOpen == 4'b1110, "R6 ack without request ignored", pageOpen, 4'b1110);
    idleCode = 4'd0;
    @(negedge clk);
    check(closeReq && closeBank == 2'd1, "R5 lowest bank first", closeBank, 1);
    ack_once();
    check(pageOpen == 4'b1100, "R5 only bank 1 closed", pageOpen, 4'b1100);
    check(closeReq && closeBank == 2'd2, "R5 next bank offered", closeBank, 2);
    ack_once();
    check(closeReq && closeBank == 2'd3, "R5 last bank offered", closeBank, 3);
    ack_once();
    check(pageOpen == 4'b0000 && !closeReq, "R5 all served", pageOpen, 0);
  endtask

  task automatic test_two_bank();
    fourBank = 1'b0;
    idleCode = 4'd0;
    @(negedge clk);
    access(2'd3);
    check(pageOpen == 4'b0000, "R7 bank 3 access ignored", pageOpen, 0);
    check(closeReq == 1'b0, "R7 no request for bank 3", closeReq, 0);
    access(2'd2);
    check(pageOpen == 4'b0000, "R7 bank 2 access ignored", pageOpen, 0);
    access(2'd0);
    check(pageOpen == 4'b0001, "R7 bank 0 still tracked", pageOpen, 1);
    check(closeReq && closeBank == 2'd0, "R7 bank 0 request", closeBank, 0);
    ack_once();
    check(pageOpen == 4'b0000, "R7 bank 0 closed", pageOpen, 0);
    fourBank = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    test_reset();
    for (int c = 0; c < 8; c++) test_timeout(c, 2'(c % 4));
    test_restart();
    test_infinite_and_order();
    test_two_bank();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule